// File: doc/BRIEF.md
# Lockstep Grid Processing Cell

This block is one processing element of a two-dimensional array of identical cores that all run the same program in lockstep. A global sequencer broadcasts one 16-bit instruction word per step to every cell. Each cell decodes that word on its own, reads its operands, runs one integer operation and writes the result back in the same cycle. No pipeline is involved. Program sequencing, call and return handling and fixed-point arithmetic are handled outside the cell.

Each cell holds one shared state register and eight private working registers. The shared state register is wired out to the four adjacent cells. The operand address space also covers values that are not stored in the cell: the four neighbours' state values, a constant zero, and the cell's own grid coordinates. Two write addresses are not registers but sinks. One raises a pixel write strobe that carries the result. The other loads a small precision setting that a separate fixed-point unit uses.

Divergent branches are handled by masking. The cell reports whether a conditional-skip instruction would skip for it. When the condition holds, the cell masks itself off, and a nesting counter tracks skipped regions that sit inside other skipped regions. A join pulse from the sequencer at the end of a region unwinds one level. A masked cell keeps fetching instructions in lockstep but changes no state.

Top module: `simd_cell`

## Requirements
- R1: After reset, all nine stored registers and the precision output are zero, active_o is 1, and video_we_o is 0.
- R2: The instruction word is split as opcode [15:12], destination [11:8], first source [7:4], second source [3:0] and immediate [7:0]. Opcode 0 writes the immediate, sign-extended to W bits, to the destination.
- R3: Opcodes 2, 3 and 9 write the sum, the difference and the product of the two sources, each truncated to W bits. Opcodes 4, 5 and 6 write the bitwise AND, OR and NOR of the two sources.
- R4: Opcode 7 writes 1 if the sources are equal and 0 otherwise. Opcode 8 writes 1 if the first source is less than the second as signed values, and 0 otherwise. Opcode 10 shifts the first source right arithmetically by the unsigned value of the second source, so shifts of W or more give all sign bits.
- R5: Source addresses 0 to 8 read the stored registers. Address 9 reads zero. Addresses 10 and 11 read the x and y coordinates, zero-extended. Addresses 12, 13, 14 and 15 read the left, right, lower and upper neighbour state.
- R6: state_o always shows register 0. Registers, precision and active state change only at a clock edge where step_i is high, except for the join action in R11.
- R7: A write to destination 9 pulses video_we_o for one cycle after the step, with the result on video_data_o. Writes to destinations 11 to 15 change nothing.
- R8: A write to destination 10 loads the low PREC_W bits of the result into prec_o.
- R9: unl_cond_o is high, combinationally, exactly when the opcode is 1, the register named by bits [11:8] reads zero, and the cell is active.
- R10: A step with opcode 1 behaves as follows. If the cell is active and the condition holds, the cell goes inactive at nesting depth 1. If the cell is inactive, the depth rises by one and saturates at NEST_MAX. If the cell is active and the condition is false, nothing changes.
- R11: join_i with step_i low lowers a nonzero depth by one. join_i is ignored while step_i is high. active_o is 1 exactly when the depth is zero.
- R12: An inactive cell writes no register, no precision value and no video strobe.
- R13: Opcodes 1 and 11 to 15 write no register, precision or video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Execute instr_i at this edge |
| instr_i | input | 16 | Broadcast instruction word |
| join_i | input | 1 | End of a skipped region; unwinds one nesting level |
| coord_x_i | input | CW | Cell x coordinate (constant) |
| coord_y_i | input | CW | Cell y coordinate (constant) |
| nb_left_i | input | W | Left neighbour state |
| nb_right_i | input | W | Right neighbour state |
| nb_down_i | input | W | Lower neighbour state |
| nb_up_i | input | W | Upper neighbour state |
| state_o | output | W | Shared state register, read by neighbours |
| active_o | output | 1 | Cell is executing (not masked) |
| unl_cond_o | output | 1 | Skip condition for the current instruction |
| video_we_o | output | 1 | Pixel write strobe |
| video_data_o | output | W | Pixel value |
| prec_o | output | PREC_W | Fixed-point precision setting |

## Verification
The embedded properties check, on every cycle, the rules that hold without regard to operand values. With no step, the state output and precision stay unchanged. A masked cell never raises the pixel strobe. The skip condition is never reported by a masked cell. Both the divergence rule and the join rule move the nesting counter as specified. Whether each opcode computes the correct value, the full operand address map with coordinates and neighbours, and the sign-extension and shift corners can only be shown by the bench's scenarios. The bench compares a step-by-step model against the outputs and reads private registers out through the pixel sink.

// File: rtl/simd_cell_pkg.sv
package simd_cell_pkg;

  typedef enum logic [3:0] {
    OP_LI   = 4'd0,
    OP_UNL  = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_NOR  = 4'd6,
    OP_SEQ  = 4'd7,
    OP_SLT  = 4'd8,
    OP_MUL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_FMUL = 4'd11,
    OP_JMP  = 4'd12,
    OP_CALL = 4'd13,
    OP_RET  = 4'd14,
    OP_EXT  = 4'd15
  } opcode_e;

  localparam int unsigned NUM_STORED = 9;
  localparam logic [3:0] A_LAST_GPR = 4'd8;
  localparam logic [3:0] A_ZERO     = 4'd9;
  localparam logic [3:0] A_CX       = 4'd10;
  localparam logic [3:0] A_CY       = 4'd11;
  localparam logic [3:0] A_NB_L     = 4'd12;
  localparam logic [3:0] A_NB_R     = 4'd13;
  localparam logic [3:0] A_NB_D     = 4'd14;
  localparam logic [3:0] A_NB_U     = 4'd15;
  localparam logic [3:0] A_VIDEO    = 4'd9;
  localparam logic [3:0] A_PREC     = 4'd10;

  typedef struct packed {
    opcode_e    op;
    logic [3:0] rd;
    logic [3:0] rs1;
    logic [3:0] rs2;
    logic [7:0] imm;
    logic       alu_wr;
    logic       wr_gpr;
    logic       wr_video;
    logic       wr_prec;
    logic       is_unl;
  } dec_t;

endpackage

// File: rtl/simd_cell_decode.sv
module simd_cell_decode
  import simd_cell_pkg::*;
(
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.op  = opcode_e'(instr_i[15:12]);
    dec_o.rd  = instr_i[11:8];
    dec_o.rs1 = instr_i[7:4];
    dec_o.rs2 = instr_i[3:0];
    dec_o.imm = instr_i[7:0];
    unique case (dec_o.op)
      OP_LI, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOR,
      OP_SEQ, OP_SLT, OP_MUL, OP_SHR: dec_o.alu_wr = 1'b1;
      default:                        dec_o.alu_wr = 1'b0;
    endcase
    dec_o.wr_gpr   = dec_o.alu_wr && (dec_o.rd <= A_LAST_GPR);
    dec_o.wr_video = dec_o.alu_wr && (dec_o.rd == A_VIDEO);
    dec_o.wr_prec  = dec_o.alu_wr && (dec_o.rd == A_PREC);
    dec_o.is_unl   = (dec_o.op == OP_UNL);
  end
endmodule

// File: rtl/simd_cell_alu.sv
module simd_cell_alu
  import simd_cell_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  opcode_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [7:0]   imm_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] imm_sx;
  assign imm_sx = W'($signed(imm_i));

  always_comb begin
    unique case (op_i)
      OP_LI:   res_o = imm_sx;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOR:  res_o = ~(a_i | b_i);
      OP_SEQ:  res_o = W'(a_i == b_i);
      OP_SLT:  res_o = W'($signed(a_i) < $signed(b_i));
      OP_MUL:  res_o = a_i * b_i;
      OP_SHR:  res_o = $unsigned($signed(a_i) >>> b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_cell_regs.sv
module simd_cell_regs
  import simd_cell_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [3:0]    raddr_a_i,
  input  logic [3:0]    raddr_b_i,
  input  logic [3:0]    raddr_c_i,
  input  logic [CW-1:0] coord_x_i,
  input  logic [CW-1:0] coord_y_i,
  input  logic [W-1:0]  nb_left_i,
  input  logic [W-1:0]  nb_right_i,
  input  logic [W-1:0]  nb_down_i,
  input  logic [W-1:0]  nb_up_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  output logic [W-1:0]  rdata_c_o,
  output logic [W-1:0]  state_o
);
  logic [W-1:0] regs_q [NUM_STORED];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_STORED); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < int'(NUM_STORED); i++)
        if (waddr_i == 4'(i)) regs_q[i] <= wdata_i;
    end
  end

  function automatic logic [W-1:0] src_sel(input logic [3:0] a);
    logic [W-1:0] v;
    v = '0;
    case (a)
      A_ZERO:  v = '0;
      A_CX:    v = W'(coord_x_i);
      A_CY:    v = W'(coord_y_i);
      A_NB_L:  v = nb_left_i;
      A_NB_R:  v = nb_right_i;
      A_NB_D:  v = nb_down_i;
      A_NB_U:  v = nb_up_i;
      default: begin
        for (int i = 0; i < int'(NUM_STORED); i++)
          if (a == 4'(i)) v = regs_q[i];
      end
    endcase
    return v;
  endfunction

  assign rdata_a_o = src_sel(raddr_a_i);
  assign rdata_b_o = src_sel(raddr_b_i);
  assign rdata_c_o = src_sel(raddr_c_i);
  assign state_o   = regs_q[0];

  AST_NO_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(state_o)); // R6
endmodule

// File: rtl/simd_cell_mask.sv
module simd_cell_mask #(
  parameter int unsigned NEST_MAX = 15,
  localparam int unsigned DW = $clog2(NEST_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic unl_i,
  input  logic cond_zero_i,
  input  logic join_i,
  output logic active_o
);
  localparam logic [DW-1:0] DEPTH_MAX = DW'(NEST_MAX);

  logic [DW-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
    end else if (step_i) begin
      if (unl_i) begin
        if (depth_q == '0) begin
          if (cond_zero_i) depth_q <= DW'(1);
        end else if (depth_q != DEPTH_MAX) begin
          depth_q <= depth_q + 1'b1;
        end
      end
    end else if (join_i && depth_q != '0) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  assign active_o = (depth_q == '0);

  AST_DIVERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && unl_i && active_o && cond_zero_i |=> !active_o); // R10
  AST_NEST_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && unl_i && depth_q == DEPTH_MAX |=> depth_q == DEPTH_MAX); // R10
  AST_JOIN_UNWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && join_i && depth_q != '0 |=> depth_q == DW'($past(depth_q) - 1'b1)); // R11
  AST_JOIN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !unl_i |=> $stable(depth_q)); // R11
endmodule

// File: rtl/simd_cell.sv
module simd_cell
  import simd_cell_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned CW       = 8,
  parameter int unsigned PREC_W   = 5,
  parameter int unsigned NEST_MAX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [15:0]       instr_i,
  input  logic              join_i,
  input  logic [CW-1:0]     coord_x_i,
  input  logic [CW-1:0]     coord_y_i,
  input  logic [W-1:0]      nb_left_i,
  input  logic [W-1:0]      nb_right_i,
  input  logic [W-1:0]      nb_down_i,
  input  logic [W-1:0]      nb_up_i,
  output logic [W-1:0]      state_o,
  output logic              active_o,
  output logic              unl_cond_o,
  output logic              video_we_o,
  output logic [W-1:0]      video_data_o,
  output logic [PREC_W-1:0] prec_o
);
  dec_t         dec;
  logic [W-1:0] src_a, src_b, src_c, alu_res;
  logic         active, commit, cond_zero;

  simd_cell_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  simd_cell_regs #(.W(W), .CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (commit && dec.wr_gpr),
    .waddr_i   (dec.rd),
    .wdata_i   (alu_res),
    .raddr_a_i (dec.rs1),
    .raddr_b_i (dec.rs2),
    .raddr_c_i (dec.rd),
    .coord_x_i (coord_x_i),
    .coord_y_i (coord_y_i),
    .nb_left_i (nb_left_i),
    .nb_right_i(nb_right_i),
    .nb_down_i (nb_down_i),
    .nb_up_i   (nb_up_i),
    .rdata_a_o (src_a),
    .rdata_b_o (src_b),
    .rdata_c_o (src_c),
    .state_o   (state_o)
  );

  simd_cell_alu #(.W(W)) u_alu (
    .op_i (dec.op),
    .a_i  (src_a),
    .b_i  (src_b),
    .imm_i(dec.imm),
    .res_o(alu_res)
  );

  assign cond_zero = (src_c == '0);

  simd_cell_mask #(.NEST_MAX(NEST_MAX)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .unl_i      (dec.is_unl),
    .cond_zero_i(cond_zero),
    .join_i     (join_i),
    .active_o   (active)
  );

  assign active_o   = active;
  assign commit     = step_i && active;
  assign unl_cond_o = dec.is_unl && cond_zero && active;

  // Sinks at addresses 9 and 10
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      video_we_o   <= 1'b0;
      video_data_o <= '0;
      prec_o       <= '0;
    end else begin
      video_we_o <= commit && dec.wr_video;
      if (commit && dec.wr_video) video_data_o <= alu_res;
      if (commit && dec.wr_prec)  prec_o <= alu_res[PREC_W-1:0];
    end
  end

  AST_MASKED_NO_VIDEO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> !video_we_o); // R12
  AST_IDLE_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_o)); // R6
  AST_COND_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unl_cond_o |-> active_o); // R9
  AST_PREC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && active_o) |=> $stable(prec_o)); // R8
  AST_VIDEO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !video_we_o); // R7
endmodule

// File: tb/sim_simd_cell.sv
`timescale 1ns/1ps
module sim_simd_cell;
  localparam int W = 16;
  localparam int CW = 8;
  localparam int PW = 5;
  localparam int NMAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step = 1'b0;
  logic [15:0]   instr = '0;
  logic          jn = 1'b0;
  logic [CW-1:0] cx = 8'd5;
  logic [CW-1:0] cy = 8'd200;
  logic [W-1:0]  nl = '0, nr = '0, nd = '0, nu = '0;
  logic [W-1:0]  state;
  logic          act, ucond, vwe;
  logic [W-1:0]  vdata;
  logic [PW-1:0] prec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit rand_nb = 1;

  logic [W-1:0]  m_regs [9];
  int            m_depth;
  logic [PW-1:0] m_prec;
  logic [W-1:0]  m_vdata;
  logic          m_vwe;

  always #2.5 clk = ~clk;

  simd_cell #(.W(W), .CW(CW), .PREC_W(PW), .NEST_MAX(NMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .instr_i(instr), .join_i(jn),
    .coord_x_i(cx), .coord_y_i(cy), .nb_left_i(nl), .nb_right_i(nr),
    .nb_down_i(nd), .nb_up_i(nu), .state_o(state), .active_o(act),
    .unl_cond_o(ucond), .video_we_o(vwe), .video_data_o(vdata), .prec_o(prec)
  );

  task automatic chk(input string tag, input logic [31:0] actv, input logic [31:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rd, input int a, input int b);
    return {4'(op), 4'(rd), 4'(a), 4'(b)};
  endfunction

  function automatic logic [15:0] enci(input int op, input int rd, input int imm);
    return {4'(op), 4'(rd), 8'(imm)};
  endfunction

  function automatic logic [W-1:0] m_read(input logic [3:0] a);
    case (a)
      4'd9:  return '0;
      4'd10: return W'(cx);
      4'd11: return W'(cy);
      4'd12: return nl;
      4'd13: return nr;
      4'd14: return nd;
      4'd15: return nu;
      default: return m_regs[a];
    endcase
  endfunction

  function automatic logic [W-1:0] m_alu(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [7:0] imm);
    logic [W-1:0] r;
    int sh;
    r = '0;
    case (op)
      4'd0:  r = {{(W-8){imm[7]}}, imm};
      4'd2:  r = a + b;
      4'd3:  r = a - b;
      4'd4:  r = a & b;
      4'd5:  r = a | b;
      4'd6:  r = ~(a | b);
      4'd7:  r = (a == b) ? W'(1) : W'(0);
      4'd8:  r = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
      4'd9:  r = W'(a * b);
      4'd10: begin
        sh = (b >= W) ? W - 1 : int'(b);
        r = a;
        for (int i = 0; i < sh; i++) r = {r[W-1], r[W-1:1]};
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check_outs();
    chk("R6 state_o", 32'(state), 32'(m_regs[0]));
    chk("R10 active_o", 32'(act), 32'(m_depth == 0));
    chk("R7 video_we_o", 32'(vwe), 32'(m_vwe));
    if (m_vwe) chk("R7 video_data_o", 32'(vdata), 32'(m_vdata));
    chk("R8 prec_o", 32'(prec), 32'(m_prec));
  endtask

  // Drive one cycle at negedge; step_on selects execution
  task automatic cycle(input bit step_on, input logic [15:0] ins, input bit join_on);
    logic [3:0] op, rd;
    logic [W-1:0] a, b, res;
    bit alive, cz, wr;
    instr = ins; step = step_on; jn = join_on;
    if (rand_nb) begin
      nl = W'($urandom); nr = W'($urandom); nd = W'($urandom); nu = W'($urandom);
    end
    #1;
    op = ins[15:12]; rd = ins[11:8];
    alive = (m_depth == 0);
    cz = (m_read(rd) == '0);
    chk("R9 unl_cond_o", 32'(ucond), 32'((op == 4'd1) && alive && cz));
    a = m_read(ins[7:4]); b = m_read(ins[3:0]);
    res = m_alu(op, a, b, ins[7:0]);
    wr = (op == 4'd0) || (op >= 4'd2 && op <= 4'd10);
    m_vwe = 1'b0;
    if (step_on) begin
      if (op == 4'd1) begin
        if (alive) begin
          if (cz) m_depth = 1;
        end else if (m_depth < NMAX) m_depth++;
      end
      if (alive && wr) begin
        if (rd <= 4'd8) m_regs[rd] = res;
        else if (rd == 4'd9) begin m_vwe = 1'b1; m_vdata = res; end
        else if (rd == 4'd10) m_prec = res[PW-1:0];
      end
    end else if (join_on && m_depth > 0) m_depth--;
    @(negedge clk);
    check_outs();
  endtask

  task automatic run(input logic [15:0] ins);
    cycle(1'b1, ins, 1'b0);
  endtask

  // Read a stored register out through the pixel sink
  task automatic peek(input int r, input logic [W-1:0] expv, input string tag);
    run(enc(5, 9, r, 9));
    chk(tag, 32'(vdata), 32'(expv));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) m_regs[i] = '0;
    m_depth = 0; m_prec = '0; m_vdata = '0; m_vwe = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state_o", 32'(state), 0);
    chk("R1 active_o", 32'(act), 1);
    chk("R1 video_we_o", 32'(vwe), 0);
    chk("R1 prec_o", 32'(prec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 1; r <= 8; r++) peek(r, '0, "R1 reg zero");

    // R2 sign extension and field layout
    run(enci(0, 1, 8'hFD));
    peek(1, 16'hFFFD, "R2 li negative");
    run(enci(0, 0, 8'h7F));
    chk("R2 li state", 32'(state), 32'h007F);

    // R3 arithmetic and logic
    run(enci(0, 2, 100));
    run(enci(0, 3, 8'h9C));
    run(enc(2, 4, 2, 3));
    peek(4, 16'h0000, "R3 add wrap");
    run(enc(3, 4, 3, 2));
    peek(4, 16'hFF38, "R3 sub");
    run(enc(9, 4, 3, 3));
    peek(4, 16'h2710, "R3 mul");
    run(enc(6, 4, 2, 9));
    peek(4, 16'hFF9B, "R3 nor");

    // R4 compares and arithmetic shift
    run(enc(8, 5, 3, 2));
    peek(5, 16'h0001, "R4 slt signed");
    run(enc(7, 5, 3, 2));
    peek(5, 16'h0000, "R4 seq false");
    run(enci(0, 6, 8'h80));
    run(enci(0, 7, 3));
    run(enc(10, 0, 6, 7));
    chk("R4 shr by 3", 32'(state), 32'hFFF0);
    run(enci(0, 7, 20));
    run(enc(10, 0, 6, 7));
    chk("R4 shr over width", 32'(state), 32'hFFFF);

    // R5 address map
    rand_nb = 0;
    nl = 16'h1111; nr = 16'h2222; nd = 16'h3333; nu = 16'h4444;
    run(enc(5, 0, 10, 11));
    chk("R5 x|y", 32'(state), 32'h00CD);
    run(enc(2, 0, 12, 13));
    chk("R5 left+right", 32'(state), 32'h3333);
    run(enc(3, 0, 15, 14));
    chk("R5 up-down", 32'(state), 32'h1111);
    rand_nb = 1;

    // R7 write sinks, R13 non-ALU opcodes
    run(enci(0, 9, 8'h42));
    chk("R7 video strobe", 32'(vwe), 1);
    cycle(1'b0, 16'h0000, 1'b0);
    chk("R7 strobe one cycle", 32'(vwe), 0);
    run(enci(0, 13, 8'h55));
    run(enci(0, 11, 8'h55));
    run(enc(11, 1, 2, 3));
    run(enc(15, 0, 2, 3));
    peek(1, 16'hFFFD, "R13 no write");
    run(enci(0, 10, 8'h3B));
    chk("R8 prec load", 32'(prec), 32'h1B);

    // R9/R10/R11/R12 masking
    run(enci(0, 3, 0));
    cycle(1'b0, enc(1, 1, 0, 0), 1'b0);
    chk("R9 cond false on nonzero", 32'(ucond), 0);
    run(enc(1, 1, 0, 0));
    chk("R10 stays active", 32'(act), 1);
    run(enc(1, 3, 0, 0));
    chk("R10 diverge", 32'(act), 0);
    run(enci(0, 0, 9));
    run(enci(0, 9, 1));
    chk("R12 no video", 32'(vwe), 0);
    run(enci(0, 10, 2));
    chk("R12 no prec", 32'(prec), 32'h1B);
    run(enc(1, 3, 0, 0));
    cycle(1'b1, enci(0, 0, 1), 1'b1);
    chk("R11 join ignored on step", 32'(act), 0);
    cycle(1'b0, 16'h0000, 1'b1);
    chk("R11 one level left", 32'(act), 0);
    cycle(1'b0, 16'h0000, 1'b1);
    chk("R11 reactivated", 32'(act), 1);
    for (int i = 0; i < 20; i++) run(enc(1, 3, 0, 0));
    for (int i = 0; i < NMAX - 1; i++) cycle(1'b0, 16'h0000, 1'b1);
    chk("R10 saturated depth", 32'(act), 0);
    cycle(1'b0, 16'h0000, 1'b1);
    chk("R10 saturation unwound", 32'(act), 1);

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) cycle(1'b0, 16'(($urandom)), ($urandom % 2) == 1);
      else run(16'($urandom));
    end
    while (m_depth != 0) cycle(1'b0, 16'h0000, 1'b1);
    for (int r = 0; r <= 8; r++) peek(r, m_regs[r], "R6 final regs");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule